// File: doc/BRIEF.md
# Home and Position Compare Event Unit

This block sits beside an incremental encoder's counting logic and turns what happens on the shaft into four sticky event flags: watchdog expiry, home detection, position-compare match and the index (Z) event. Each flag stays set until software writes a 1 to its bit. The flags feed four independent enable masks, one per consumer: a level interrupt, a level DMA request, a one-cycle trigger pulse and a one-cycle strobe that tells neighbouring logic to load the counters into their read registers.

Home detection follows the home line with a two-state tracker. State H_LOW moves to H_HIGH when the line is seen high (a rising edge). H_HIGH moves back to H_LOW when the line is seen low (a falling edge). Each edge is qualified by the current rotation direction through one of four enable bits. Position compare uses a second tracker. State CMP_ARMED moves to CMP_LATCHED on the first cycle the match condition holds, and only that transition raises the flag. CMP_LATCHED returns to CMP_ARMED as soon as the match is lost. The match always includes the phase count. The revolution count and the direction are each included unless their disable input is set.

Top module: `qevt_event_unit`

## Requirements
- R1: After reset the status word is zero and the interrupt, DMA request, trigger and load outputs are all 0.
- R2: A home-line edge sets the home flag (status bit 30) only if its enable bit in `home_sel_i` is 1. The bit index is {falling, dir}: bit 0 is rising with dir 0, bit 1 is rising with dir 1, bit 2 is falling with dir 0 and bit 3 is falling with dir 1. Any other edge leaves the flag clear. The flag is visible one clock after the edge is sampled.
- R3: A cycle with `wdg_expire_i` high sets status bit 31. A cycle with `z_evt_i` high sets status bit 28. Both flags are visible after one clock.
- R4: The position flag (status bit 29) sets only on the first cycle of a match. If it is cleared while the match still holds, it stays clear. It sets again only after the match has been lost and then found again.
- R5: With `cmp_rev_ignore_i` at 0, a match also needs `rev_i` equal to `cmp_rev_i`. With it at 1, the revolution count is not part of the match.
- R6: With `cmp_dir_ignore_i` at 0, a match also needs `dir_i` equal to `cmp_dir_i` (0 is positive rotation, 1 is negative). With it at 1, direction is not part of the match.
- R7: A cycle with `clr_wr_i` high clears each flag whose bit in `clr_word_i` (bits 31..28) is 1. Zero bits and bits 27..0 have no effect. If a flag is set and cleared in the same cycle, the set wins.
- R8: `irq_o` is the OR over the four flags of (flag AND the matching bit of `irq_en_i`). `dma_req_o` is formed the same way from `dma_en_i`.
- R9: `trig_o` pulses for exactly one cycle, in the same cycle a flag first shows as 1, when that flag's bit in `trig_en_i` is 1. A flag that is already set and is set again gives no pulse.
- R10: `load_o` follows the rule of R9, using `load_en_i`.
- R11: Status bits 27..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | PH_W | Phase count |
| rev_i | input | REV_W | Revolution count |
| dir_i | input | 1 | Rotation direction, 1 is negative |
| home_i | input | 1 | Home line, already synchronous |
| z_evt_i | input | 1 | Index event pulse |
| wdg_expire_i | input | 1 | Watchdog expiry pulse |
| home_sel_i | input | 4 | Home edge/direction enables |
| cmp_phase_i | input | PH_W | Phase compare value |
| cmp_rev_i | input | REV_W | Revolution compare value |
| cmp_rev_ignore_i | input | 1 | Leave revolution count out of the match |
| cmp_dir_ignore_i | input | 1 | Leave direction out of the match |
| cmp_dir_i | input | 1 | Required direction for a match |
| clr_wr_i | input | 1 | Write-one-to-clear strobe |
| clr_word_i | input | 32 | Clear word, flags at bits 31..28 |
| irq_en_i | input | 32 | Interrupt enables, bits 31..28 |
| dma_en_i | input | 32 | DMA request enables, bits 31..28 |
| trig_en_i | input | 32 | Trigger pulse enables, bits 31..28 |
| load_en_i | input | 32 | Read-load strobe enables, bits 31..28 |
| status_o | output | 32 | Flags: 31 watchdog, 30 home, 29 position, 28 Z |
| irq_o | output | 1 | Interrupt request level |
| dma_req_o | output | 1 | DMA request level |
| trig_o | output | 1 | One-cycle trigger pulse |
| load_o | output | 1 | One-cycle read-register load strobe |

## Verification
If the home tracker holds the wrong line level, a home flag appears with no real edge, or an edge is missed. Either shows on status bit 30 one clock after the home line is sampled. If the compare tracker is stuck in CMP_LATCHED, the position flag never rises. If it is stuck in CMP_ARMED, the flag comes back right after being cleared while the match still holds. Either shows on status bit 29 within one clock. A flag register that keeps a stale value shows at once on the interrupt and DMA levels, and a wrong 0-to-1 detection shows on the trigger and load pulses in the cycle the flag appears.

// File: rtl/qevt_pkg.sv
package qevt_pkg;
    localparam int WORD_W     = 32;
    localparam int FLAG_N     = 4;
    localparam int FLAG_LSB   = WORD_W - FLAG_N;
    localparam int HOME_SEL_W = 4;
    // flag index within the 4-bit field (word bit = FLAG_LSB + index)
    localparam int FLG_Z    = 0;
    localparam int FLG_POS  = 1;
    localparam int FLG_HOME = 2;
    localparam int FLG_WDG  = 3;

    typedef enum logic { H_LOW, H_HIGH } home_state_e;
    typedef enum logic { CMP_ARMED, CMP_LATCHED } cmp_state_e;
endpackage

// File: rtl/qevt_home_edge.sv
module qevt_home_edge
    import qevt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  home_i,
    input  logic                  dir_i,
    input  logic [HOME_SEL_W-1:0] sel_i,
    output logic                  hit_o
);
    home_state_e state_q, state_d;
    logic        edge_seen;
    logic        edge_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= H_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        edge_seen = 1'b0;
        edge_fall = 1'b0;
        unique case (state_q)
            H_LOW: begin
                if (home_i) begin
                    state_d   = H_HIGH;
                    edge_seen = 1'b1;
                end
            end
            H_HIGH: begin
                if (!home_i) begin
                    state_d   = H_LOW;
                    edge_seen = 1'b1;
                    edge_fall = 1'b1;
                end
            end
        endcase
        // enable index is {falling, direction}
        hit_o = edge_seen && sel_i[{edge_fall, dir_i}];
    end
endmodule

// File: rtl/qevt_pos_cmp.sv
module qevt_pos_cmp
    import qevt_pkg::*;
#(
    parameter int PH_W  = 21,
    parameter int REV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  phase_i,
    input  logic [REV_W-1:0] rev_i,
    input  logic             dir_i,
    input  logic [PH_W-1:0]  cmp_phase_i,
    input  logic [REV_W-1:0] cmp_rev_i,
    input  logic             rev_ignore_i,
    input  logic             dir_ignore_i,
    input  logic             cmp_dir_i,
    output logic             hit_o
);
    cmp_state_e state_q, state_d;
    logic       match;

    assign match = (phase_i == cmp_phase_i)
                && (rev_ignore_i || (rev_i == cmp_rev_i))
                && (dir_ignore_i || (dir_i == cmp_dir_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMP_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        hit_o   = 1'b0;
        unique case (state_q)
            CMP_ARMED: begin
                if (match) begin
                    state_d = CMP_LATCHED;
                    hit_o   = 1'b1;
                end
            end
            CMP_LATCHED: begin
                if (!match) state_d = CMP_ARMED;
            end
        endcase
    end
endmodule

// File: rtl/qevt_flag_bank.sv
module qevt_flag_bank
    import qevt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] set_i,
    input  logic [FLAG_N-1:0] clr_i,
    input  logic [FLAG_N-1:0] irq_en_i,
    input  logic [FLAG_N-1:0] dma_en_i,
    input  logic [FLAG_N-1:0] trig_en_i,
    input  logic [FLAG_N-1:0] load_en_i,
    output logic [FLAG_N-1:0] flags_o,
    output logic              irq_o,
    output logic              dma_o,
    output logic              trig_o,
    output logic              load_o
);
    logic [FLAG_N-1:0] newly;
    logic              trig_q;
    logic              load_q;

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         bit_q <= 1'b0;
            else if (set_i[g])  bit_q <= 1'b1;
            else if (clr_i[g])  bit_q <= 1'b0;
        end
        assign flags_o[g] = bit_q;
        assign newly[g]   = set_i[g] & ~bit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            load_q <= 1'b0;
        end else begin
            trig_q <= |(newly & trig_en_i);
            load_q <= |(newly & load_en_i);
        end
    end

    assign irq_o  = |(flags_o & irq_en_i);
    assign dma_o  = |(flags_o & dma_en_i);
    assign trig_o = trig_q;
    assign load_o = load_q;
endmodule

// File: rtl/qevt_event_unit.sv
module qevt_event_unit
    import qevt_pkg::*;
#(
    parameter int PH_W  = 21,
    parameter int REV_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PH_W-1:0]       phase_i,
    input  logic [REV_W-1:0]      rev_i,
    input  logic                  dir_i,
    input  logic                  home_i,
    input  logic                  z_evt_i,
    input  logic                  wdg_expire_i,
    input  logic [HOME_SEL_W-1:0] home_sel_i,
    input  logic [PH_W-1:0]       cmp_phase_i,
    input  logic [REV_W-1:0]      cmp_rev_i,
    input  logic                  cmp_rev_ignore_i,
    input  logic                  cmp_dir_ignore_i,
    input  logic                  cmp_dir_i,
    input  logic                  clr_wr_i,
    input  logic [WORD_W-1:0]     clr_word_i,
    input  logic [WORD_W-1:0]     irq_en_i,
    input  logic [WORD_W-1:0]     dma_en_i,
    input  logic [WORD_W-1:0]     trig_en_i,
    input  logic [WORD_W-1:0]     load_en_i,
    output logic [WORD_W-1:0]     status_o,
    output logic                  irq_o,
    output logic                  dma_req_o,
    output logic                  trig_o,
    output logic                  load_o
);
    logic              home_hit;
    logic              pos_hit;
    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] clr_vec;
    logic [FLAG_N-1:0] flags;
    logic              unused_low_bits;

    qevt_home_edge u_home (
        .clk    (clk),
        .rst_n  (rst_n),
        .home_i (home_i),
        .dir_i  (dir_i),
        .sel_i  (home_sel_i),
        .hit_o  (home_hit)
    );

    qevt_pos_cmp #(.PH_W(PH_W), .REV_W(REV_W)) u_pos (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_i      (phase_i),
        .rev_i        (rev_i),
        .dir_i        (dir_i),
        .cmp_phase_i  (cmp_phase_i),
        .cmp_rev_i    (cmp_rev_i),
        .rev_ignore_i (cmp_rev_ignore_i),
        .dir_ignore_i (cmp_dir_ignore_i),
        .cmp_dir_i    (cmp_dir_i),
        .hit_o        (pos_hit)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLG_WDG]  = wdg_expire_i;
        set_vec[FLG_HOME] = home_hit;
        set_vec[FLG_POS]  = pos_hit;
        set_vec[FLG_Z]    = z_evt_i;
        clr_vec           = clr_wr_i ? clr_word_i[FLAG_LSB +: FLAG_N] : '0;
    end

    qevt_flag_bank u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .clr_i     (clr_vec),
        .irq_en_i  (irq_en_i[FLAG_LSB +: FLAG_N]),
        .dma_en_i  (dma_en_i[FLAG_LSB +: FLAG_N]),
        .trig_en_i (trig_en_i[FLAG_LSB +: FLAG_N]),
        .load_en_i (load_en_i[FLAG_LSB +: FLAG_N]),
        .flags_o   (flags),
        .irq_o     (irq_o),
        .dma_o     (dma_req_o),
        .trig_o    (trig_o),
        .load_o    (load_o)
    );

    always_comb begin
        status_o                      = '0;
        status_o[FLAG_LSB +: FLAG_N]  = flags;
    end

    assign unused_low_bits = ^{clr_word_i[FLAG_LSB-1:0], irq_en_i[FLAG_LSB-1:0],
                               dma_en_i[FLAG_LSB-1:0], trig_en_i[FLAG_LSB-1:0],
                               load_en_i[FLAG_LSB-1:0]};
endmodule

// File: rtl/qevt_event_unit_chk.sv
module qevt_event_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        home_i,
    input logic        wdg_expire_i,
    input logic        clr_wr_i,
    input logic [31:0] clr_word_i,
    input logic [31:0] status_o,
    input logic        trig_o,
    input logic        load_o
);
    a_r2_home_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[30]) |-> ($past(home_i) != $past(home_i, 2)));

    a_r3_wdg_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_expire_i |=> status_o[31]);

    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_word_i[31] && !wdg_expire_i) |=> !status_o[31]);

    a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && !clr_word_i[31] && status_o[31]) |=> status_o[31]);

    a_r9_trig_on_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> |(status_o[31:28] & ~$past(status_o[31:28])));

    a_r10_load_on_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> |(status_o[31:28] & ~$past(status_o[31:28])));
endmodule

bind qevt_event_unit qevt_event_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .home_i       (home_i),
    .wdg_expire_i (wdg_expire_i),
    .clr_wr_i     (clr_wr_i),
    .clr_word_i   (clr_word_i),
    .status_o     (status_o),
    .trig_o       (trig_o),
    .load_o       (load_o)
);

// File: tb/qevt_event_unit_tb_top.sv
module qevt_event_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] phase_i = '0;
    logic [31:0] rev_i = '0;
    logic        dir_i = 1'b0;
    logic        home_i = 1'b0;
    logic        z_evt_i = 1'b0;
    logic        wdg_expire_i = 1'b0;
    logic [3:0]  home_sel_i = '0;
    logic [20:0] cmp_phase_i = 21'd37;
    logic [31:0] cmp_rev_i = 32'd1000;
    logic        cmp_rev_ignore_i = 1'b1;
    logic        cmp_dir_ignore_i = 1'b1;
    logic        cmp_dir_i = 1'b0;
    logic        clr_wr_i = 1'b0;
    logic [31:0] clr_word_i = '0;
    logic [31:0] irq_en_i = '0;
    logic [31:0] dma_en_i = '0;
    logic [31:0] trig_en_i = '0;
    logic [31:0] load_en_i = '0;
    logic [31:0] status_o;
    logic        irq_o, dma_req_o, trig_o, load_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    qevt_event_unit dut_i (.*);

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_wr_i = 1'b1; clr_word_i = '1;
        step();
        clr_wr_i = 1'b0; clr_word_i = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 status", status_o, 32'h0);
        chk("R1 outputs", {28'h0, irq_o, dma_req_o, trig_o, load_o}, 32'h0);

        // R2 sweep: direction x edge polarity x all enable masks
        for (int d = 0; d < 2; d++) begin
            for (int f = 0; f < 2; f++) begin
                for (int s = 0; s < 16; s++) begin
                    logic [3:0] sv;
                    sv = 4'(s);
                    home_sel_i = '0; dir_i = d[0]; home_i = f[0];
                    step(); step();
                    clear_all();
                    home_sel_i = sv; home_i = ~f[0];
                    step();
                    chk("R2 home flag", {31'h0, status_o[30]}, {31'h0, sv[f*2+d]});
                end
            end
        end
        home_sel_i = '0; home_i = 1'b0; dir_i = 1'b0;
        step();

        // R5 R6 sweep of compare qualifiers
        for (int k = 0; k < 32; k++) begin
            logic ri, di, rm, dm, cd, e;
            {ri, di, rm, dm, cd} = 5'(k);
            phase_i = '0;
            step();
            clear_all();
            cmp_rev_ignore_i = ri; cmp_dir_ignore_i = di; cmp_dir_i = cd;
            rev_i = rm ? 32'd1000 : 32'd999;
            dir_i = dm ? cd : ~cd;
            phase_i = 21'd37;
            step();
            e = (ri | rm) & (di | dm);
            chk("R5 R6 pos flag", {31'h0, status_o[29]}, {31'h0, e});
        end

        // R4 first-cycle only, re-arm after loss
        cmp_rev_ignore_i = 1'b1; cmp_dir_ignore_i = 1'b1;
        phase_i = '0; step(); clear_all();
        phase_i = 21'd37; step();
        chk("R4 set on match", {31'h0, status_o[29]}, 32'h1);
        clear_all();
        chk("R4 cleared while held", {31'h0, status_o[29]}, 32'h0);
        step(); step();
        chk("R4 no retrigger", {31'h0, status_o[29]}, 32'h0);
        phase_i = 21'd36; step();
        phase_i = 21'd37; step();
        chk("R4 re-armed", {31'h0, status_o[29]}, 32'h1);
        phase_i = '0; step(); clear_all();

        // R3 and R7
        wdg_expire_i = 1'b1; z_evt_i = 1'b1; step();
        wdg_expire_i = 1'b0; z_evt_i = 1'b0;
        chk("R3 wdg and z set", status_o, 32'h9000_0000);
        clr_wr_i = 1'b1; clr_word_i = 32'h0000_0000; step();
        chk("R7 zero write", status_o, 32'h9000_0000);
        clr_word_i = 32'h0FFF_FFFF; step();
        chk("R7 low bits ignored", status_o, 32'h9000_0000);
        clr_word_i = 32'h8000_0000; step();
        chk("R7 clear wdg only", status_o, 32'h1000_0000);
        wdg_expire_i = 1'b1; step();
        wdg_expire_i = 1'b0; clr_wr_i = 1'b0; clr_word_i = '0;
        chk("R7 set wins", status_o, 32'h9000_0000);

        // R8 sweep of masks with flags 1001
        for (int m = 0; m < 16; m++) begin
            logic [3:0] mv;
            mv = 4'(m);
            irq_en_i = {mv, 28'h0}; dma_en_i = {~mv, 28'h0};
            step();
            chk("R8 irq", {31'h0, irq_o}, {31'h0, |(mv & 4'b1001)});
            chk("R8 dma", {31'h0, dma_req_o}, {31'h0, |(~mv & 4'b1001)});
        end
        clear_all();
        irq_en_i = '1; dma_en_i = '1; step();
        chk("R8 no flags", {30'h0, irq_o, dma_req_o}, 32'h0);
        irq_en_i = '0; dma_en_i = '0;

        // R9 R10 sweep on wdg and z flags
        for (int m = 0; m < 16; m++) begin
            logic [3:0] mv;
            mv = 4'(m);
            clear_all();
            trig_en_i = {mv, 28'h0}; load_en_i = {~mv, 28'h0};
            wdg_expire_i = 1'b1; step(); wdg_expire_i = 1'b0;
            chk("R9 trig wdg", {31'h0, trig_o}, {31'h0, mv[3]});
            chk("R10 load wdg", {31'h0, load_o}, {31'h0, ~mv[3]});
            step();
            chk("R9 R10 one cycle", {30'h0, trig_o, load_o}, 32'h0);
            wdg_expire_i = 1'b1; step(); wdg_expire_i = 1'b0;
            chk("R9 R10 already set", {30'h0, trig_o, load_o}, 32'h0);
            z_evt_i = 1'b1; step(); z_evt_i = 1'b0;
            chk("R9 trig z", {31'h0, trig_o}, {31'h0, mv[0]});
            chk("R10 load z", {31'h0, load_o}, {31'h0, ~mv[0]});
            chk("R11 reserved zero", {4'h0, status_o[27:0]}, 32'h0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule